// File: doc/BRIEF.md
# Auto-Negotiation Restart Sequencer

This block decides when an Ethernet PHY may send data, when it must stay silent, and when it sends fast-link-pulse bursts. It sits between the management control bits and the pulse and link logic. A renegotiation request, whether written by software or raised by its own seek window timing out, first forces a silent break interval. During the break no data and no link pulses go out, so the partner drops into link-fail. Only after the break does burst signalling start.

When a resolution is reported with a valid link, or a parallel-detect evaluation finds a single good technology, the sequencer raises its completion flag. If that link later fails, the sequencer goes back to seeking on its own.

A device strapped to forced operation ignores an enable bit that is merely held high. It enters negotiation only when the enable bit goes low and then high again. Any parallel-detect outcome other than exactly one good link sets a sticky fault flag, which only a read-clear strobe removes. Break and seek lengths are parameters in clock ticks.

Top module: `an_restart_seq`

## Requirements
- R1: After reset with `boot_forced`=1 all outputs are 0. After reset with `boot_forced`=0, `flp_enable` is 1 and `tx_inhibit` is 0.
- R2: A one-cycle `mgmt_restart_wr` pulse makes `restart_bit` read 1 on the next cycle and 0 on the cycle after. In the seek, break or complete condition, `tx_inhibit` is 1 in that same later cycle.
- R3: A break holds `tx_inhibit`=1 and `flp_enable`=0 for exactly BREAK_TICKS cycles. `flp_enable` then rises in the cycle that `tx_inhibit` falls.
- R4: A restart accepted during a break restarts the break count. `tx_inhibit` stays high for BREAK_TICKS+1 cycles after the cycle in which the request was written.
- R5: In the forced condition, keeping `mgmt_enable` at 1 has no effect, and a restart write is discarded: `tx_inhibit` stays 0.
- R6: In the forced condition, `mgmt_enable` going from 0 to 1 puts the block in a break on the next cycle.
- R7: With `mgmt_enable`=0, on the next cycle `tx_inhibit`, `flp_enable` and `an_complete` are all 0.
- R8: While seeking, `neg_resolved`=1 together with `link_valid`=1 sets `an_complete`=1 and `flp_enable`=0 on the next cycle. The complete state has no timeout.
- R9: When `link_valid`=0 while complete, the next cycle shows `flp_enable`=1 and `an_complete`=0, with no break.
- R10: While seeking, a `pd_eval` strobe whose `pd_links` vector has exactly one bit set gives `an_complete`=1 on the next cycle. Any other count of set bits (zero, two or more) sets `pd_fault` instead.
- R11: `pd_fault` holds until a `fault_rd_clr` strobe clears it on the next cycle. When a new fault and a clear arrive in the same cycle, the fault stays set.
- R12: Seeking for NEG_TICKS cycles without a resolution starts a break.
- R13: A `pd_eval` strobe outside the seek condition changes neither `pd_fault` nor `an_complete`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_forced | input | 1 | Strap: start in the forced (non-negotiating) condition |
| mgmt_restart_wr | input | 1 | Strobe: software wrote 1 to the restart bit |
| mgmt_enable | input | 1 | Level of the negotiation enable bit |
| link_valid | input | 1 | Link in the resolved mode is valid |
| neg_resolved | input | 1 | Ability exchange reached a common mode |
| pd_eval | input | 1 | Strobe: parallel-detect result on `pd_links` is ready |
| pd_links | input | LINK_N | One bit per technology seen with a good link |
| fault_rd_clr | input | 1 | Read-clear strobe for the fault flag |
| restart_bit | output | 1 | Read value of the self-clearing restart bit |
| tx_inhibit | output | 1 | Break: data and link pulses silenced |
| flp_enable | output | 1 | Burst signalling allowed |
| an_complete | output | 1 | Negotiation or parallel detection complete |
| pd_fault | output | 1 | Sticky parallel-detect fault flag |

## Verification
The hardest case to reach from the ports is a parallel-detect verdict that arrives inside a fresh seek window. The seek timer keeps sending the block back into breaks, and a completion made earlier moves it out of seeking. To reach that case, the bench issues a restart before every random `pd_links` draw, waits for the break to end, and clears the sticky flag before the strobe. A restart that lands inside a running break is placed at random offsets. Those offsets stay clear of the expiry cycle, so the measured stretch must always come out as one break plus one cycle.

// File: rtl/an_seq_pkg.sv
package an_seq_pkg;

  typedef enum logic [1:0] {
    AN_FORCED = 2'd0,
    AN_BREAK  = 2'd1,
    AN_SEEK   = 2'd2,
    AN_LINKED = 2'd3
  } an_state_e;

  // bits needed to count 0 .. max(a,b)-1
  function automatic int unsigned tick_width(int unsigned a, int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

endpackage

// File: rtl/an_mgmt_bits.sv
module an_mgmt_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_wr,
  input  logic enable,
  output logic restart_q,
  output logic en_rise,
  output logic en_low
);

  logic en_q;

  // en_q resets to 1 so a bit held high through reset is no edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      restart_q <= 1'b0;
      en_q      <= 1'b1;
    end else begin
      restart_q <= restart_wr;
      en_q      <= enable;
    end
  end

  assign en_rise = enable & ~en_q;
  assign en_low  = ~enable;

endmodule

// File: rtl/an_tick_timer.sv
module an_tick_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] limit_m1,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  function automatic logic at_end(logic [CNT_W-1:0] c, logic [CNT_W-1:0] lim);
    return c == lim;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (clr)
      cnt_q <= '0;
    else if (run && !at_end(cnt_q, limit_m1))
      cnt_q <= cnt_q + CNT_W'(1);
  end

  assign expired = run & at_end(cnt_q, limit_m1);

endmodule

// File: rtl/an_pd_judge.sv
module an_pd_judge #(
  parameter int unsigned LINK_N = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_ok,
  input  logic [LINK_N-1:0] links,
  input  logic              rd_clr,
  output logic              single_ok,
  output logic              fault_set,
  output logic              fault
);

  function automatic logic exactly_one(logic [LINK_N-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < LINK_N; i++) n += v[i] ? 1 : 0;
    return n == 1;
  endfunction

  logic one_w;
  assign one_w     = exactly_one(links);
  assign single_ok = eval_ok & one_w;
  assign fault_set = eval_ok & ~one_w;

  // a new fault outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)
      fault <= 1'b0;
    else if (fault_set)
      fault <= 1'b1;
    else if (rd_clr)
      fault <= 1'b0;
  end

endmodule

// File: rtl/an_seq_fsm.sv
module an_seq_fsm
  import an_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      boot_forced,
  input  logic      en_rise,
  input  logic      en_low,
  input  logic      restart_take,
  input  logic      link_valid,
  input  logic      neg_resolved,
  input  logic      pd_single,
  input  logic      tmr_expired,
  output an_state_e st_q,
  output logic      tmr_clr,
  output logic      tmr_run,
  output logic      sel_break
);

  an_state_e st_n;
  logic      reload;

  always_comb begin
    st_n   = st_q;
    reload = 1'b0;
    if (en_low) begin
      st_n = AN_FORCED;
    end else begin
      case (st_q)
        AN_FORCED: if (en_rise) st_n = AN_BREAK;
        AN_BREAK: begin
          if (restart_take)     reload = 1'b1;
          else if (tmr_expired) st_n = AN_SEEK;
        end
        AN_SEEK: begin
          if (restart_take)                                 st_n = AN_BREAK;
          else if ((neg_resolved && link_valid) || pd_single) st_n = AN_LINKED;
          else if (tmr_expired)                             st_n = AN_BREAK;
        end
        AN_LINKED: begin
          if (restart_take)     st_n = AN_BREAK;
          else if (!link_valid) st_n = AN_SEEK;
        end
        default: st_n = AN_FORCED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      st_q <= boot_forced ? AN_FORCED : AN_SEEK;
    else
      st_q <= st_n;
  end

  assign tmr_clr   = reload | (st_n != st_q);
  assign tmr_run   = (st_q == AN_BREAK) | (st_q == AN_SEEK);
  assign sel_break = (st_q == AN_BREAK);

endmodule

// File: rtl/an_restart_seq.sv
module an_restart_seq
  import an_seq_pkg::*;
#(
  parameter int unsigned LINK_N      = 3,
  parameter int unsigned BREAK_TICKS = 187_500_000,
  parameter int unsigned NEG_TICKS   = 375_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_forced,
  input  logic              mgmt_restart_wr,
  input  logic              mgmt_enable,
  input  logic              link_valid,
  input  logic              neg_resolved,
  input  logic              pd_eval,
  input  logic [LINK_N-1:0] pd_links,
  input  logic              fault_rd_clr,
  output logic              restart_bit,
  output logic              tx_inhibit,
  output logic              flp_enable,
  output logic              an_complete,
  output logic              pd_fault
);

  localparam int unsigned      CNT_W  = tick_width(BREAK_TICKS, NEG_TICKS);
  localparam logic [CNT_W-1:0] BRK_M1 = CNT_W'(BREAK_TICKS - 1);
  localparam logic [CNT_W-1:0] NEG_M1 = CNT_W'(NEG_TICKS - 1);

  // named internal events, also used by the bound checker
  logic      en_rise_w, en_low_w, restart_q;
  logic      fault_set_w, pd_single_w, in_forced_w;
  logic      tmr_clr, tmr_run, tmr_exp, sel_break;
  an_state_e st_q;

  an_mgmt_bits u_bits (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart_wr (mgmt_restart_wr),
    .enable     (mgmt_enable),
    .restart_q  (restart_q),
    .en_rise    (en_rise_w),
    .en_low     (en_low_w)
  );

  an_tick_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (tmr_clr),
    .run      (tmr_run),
    .limit_m1 (sel_break ? BRK_M1 : NEG_M1),
    .expired  (tmr_exp)
  );

  an_pd_judge #(.LINK_N(LINK_N)) u_pd (
    .clk       (clk),
    .rst_n     (rst_n),
    .eval_ok   (pd_eval & (st_q == AN_SEEK)),
    .links     (pd_links),
    .rd_clr    (fault_rd_clr),
    .single_ok (pd_single_w),
    .fault_set (fault_set_w),
    .fault     (pd_fault)
  );

  an_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .boot_forced  (boot_forced),
    .en_rise      (en_rise_w),
    .en_low       (en_low_w),
    .restart_take (restart_q),
    .link_valid   (link_valid),
    .neg_resolved (neg_resolved),
    .pd_single    (pd_single_w),
    .tmr_expired  (tmr_exp),
    .st_q         (st_q),
    .tmr_clr      (tmr_clr),
    .tmr_run      (tmr_run),
    .sel_break    (sel_break)
  );

  assign in_forced_w = (st_q == AN_FORCED);
  assign restart_bit = restart_q;
  assign tx_inhibit  = (st_q == AN_BREAK);
  assign flp_enable  = (st_q == AN_SEEK);
  assign an_complete = (st_q == AN_LINKED);

endmodule

// File: rtl/an_restart_seq_chk.sv
module an_restart_seq_chk #(
  parameter int unsigned BREAK_TICKS = 4
) (
  input logic clk,
  input logic rst_n,
  input logic mgmt_restart_wr,
  input logic mgmt_enable,
  input logic link_valid,
  input logic restart_bit,
  input logic tx_inhibit,
  input logic flp_enable,
  input logic an_complete,
  input logic pd_fault,
  input logic fault_rd_clr,
  input logic fault_set_evt,
  input logic en_rise_evt,
  input logic in_forced
);

  // consecutive break cycles since the last accepted request
  logic [31:0] brk_run;
  always_ff @(posedge clk) begin
    if (!rst_n || !tx_inhibit || restart_bit) brk_run <= '0;
    else                                      brk_run <= brk_run + 32'd1;
  end

  assert_break_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_inhibit |-> (!flp_enable && !an_complete));

  assert_break_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_inhibit |-> (brk_run < BREAK_TICKS));

  assert_restart_selfclear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_bit && !mgmt_restart_wr) |=> !restart_bit);

  assert_enable_low_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mgmt_enable |=> (!tx_inhibit && !flp_enable && !an_complete));

  assert_held_enable_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_forced && !en_rise_evt) |=> !tx_inhibit);

  assert_rise_starts_break_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_forced && en_rise_evt) |=> tx_inhibit);

  assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_fault && !fault_rd_clr) |=> pd_fault);

  assert_fault_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_rd_clr && !fault_set_evt) |=> !pd_fault);

  assert_fault_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_set_evt |=> pd_fault);

  assert_link_loss_seek_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (an_complete && !link_valid && mgmt_enable && !restart_bit) |=> flp_enable);

endmodule

bind an_restart_seq an_restart_seq_chk #(.BREAK_TICKS(BREAK_TICKS)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .mgmt_restart_wr (mgmt_restart_wr),
  .mgmt_enable     (mgmt_enable),
  .link_valid      (link_valid),
  .restart_bit     (restart_bit),
  .tx_inhibit      (tx_inhibit),
  .flp_enable      (flp_enable),
  .an_complete     (an_complete),
  .pd_fault        (pd_fault),
  .fault_rd_clr    (fault_rd_clr),
  .fault_set_evt   (fault_set_w),
  .en_rise_evt     (en_rise_w),
  .in_forced       (in_forced_w)
);

// File: tb/an_restart_seq_test.sv
`timescale 1ns/1ps
module an_restart_seq_test;

  localparam int unsigned LN  = 3;
  localparam int unsigned BRK = 20;
  localparam int unsigned NEG = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boot_forced = 1'b1;
  logic mgmt_restart_wr = 1'b0;
  logic mgmt_enable = 1'b1;
  logic link_valid = 1'b0;
  logic neg_resolved = 1'b0;
  logic pd_eval = 1'b0;
  logic [LN-1:0] pd_links = '0;
  logic fault_rd_clr = 1'b0;
  logic restart_bit, tx_inhibit, flp_enable, an_complete, pd_fault;

  int n_run = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  an_restart_seq #(.LINK_N(LN), .BREAK_TICKS(BRK), .NEG_TICKS(NEG)) uut (
    .clk(clk), .rst_n(rst_n), .boot_forced(boot_forced),
    .mgmt_restart_wr(mgmt_restart_wr), .mgmt_enable(mgmt_enable),
    .link_valid(link_valid), .neg_resolved(neg_resolved),
    .pd_eval(pd_eval), .pd_links(pd_links), .fault_rd_clr(fault_rd_clr),
    .restart_bit(restart_bit), .tx_inhibit(tx_inhibit),
    .flp_enable(flp_enable), .an_complete(an_complete), .pd_fault(pd_fault)
  );

  // expected verdict: good only with exactly one technology
  function automatic logic pd_good(logic [LN-1:0] v);
    int c = 0;
    for (int i = 0; i < LN; i++) if (v[i]) c++;
    return c == 1;
  endfunction

  // samples a restart-in-break leaves after the write cycle
  function automatic int tail_after_restart();
    return BRK + 1;
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic count_tx(output int n);
    n = 0;
    while (tx_inhibit) begin n++; tick(1); end
  endtask

  task automatic count_flp(output int n);
    n = 0;
    while (flp_enable) begin n++; tick(1); end
  endtask

  task automatic pulse_restart();
    mgmt_restart_wr = 1'b1; tick(1); mgmt_restart_wr = 1'b0;
  endtask

  // restart, then wait out the break: lands in a fresh seek window
  task automatic fresh_seek();
    int n;
    pulse_restart(); tick(1);
    count_tx(n);
    chk("R3 break length", n, BRK);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    int n;
    logic [LN-1:0] v;
    void'($urandom(32'd2024));

    tick(3);
    rst_n = 1'b1;
    chk("R1 forced tx", tx_inhibit, 0);
    chk("R1 forced flp", flp_enable, 0);
    chk("R1 forced done", an_complete, 0);
    chk("R1 forced fault", pd_fault, 0);
    chk("R1 forced restart", restart_bit, 0);

    tick(30);
    chk("R5 held enable tx", tx_inhibit, 0);
    chk("R5 held enable flp", flp_enable, 0);
    pulse_restart();
    chk("R2 restart bit set", restart_bit, 1);
    tick(1);
    chk("R2 restart bit clears", restart_bit, 0);
    chk("R5 restart ignored", tx_inhibit, 0);

    mgmt_enable = 1'b0; tick(1);
    chk("R7 enable low", {29'd0, tx_inhibit, flp_enable, an_complete}, 0);
    mgmt_enable = 1'b1; tick(1);
    chk("R6 rise breaks", tx_inhibit, 1);
    count_tx(n);
    chk("R3 break length", n, BRK);
    chk("R3 flp after break", flp_enable, 1);

    count_flp(n);
    chk("R12 seek window", n, NEG);
    chk("R12 timeout breaks", tx_inhibit, 1);
    count_tx(n);
    chk("R3 break length", n, BRK);

    link_valid = 1'b1; neg_resolved = 1'b1; tick(1); neg_resolved = 1'b0;
    chk("R8 complete", an_complete, 1);
    chk("R8 flp off", flp_enable, 0);
    tick(NEG + 5);
    chk("R8 no timeout", an_complete, 1);

    pulse_restart();
    chk("R2 bit while linked", restart_bit, 1);
    tick(1);
    chk("R2 linked restart breaks", tx_inhibit, 1);
    count_tx(n);
    chk("R3 break length", n, BRK);

    neg_resolved = 1'b1; tick(1); neg_resolved = 1'b0;
    chk("R8 complete again", an_complete, 1);
    link_valid = 1'b0; tick(1);
    chk("R9 back to seek", flp_enable, 1);
    chk("R9 complete drops", an_complete, 0);
    chk("R9 no break", tx_inhibit, 0);

    for (int k = 0; k < 5; k++) begin
      int d;
      d = $urandom_range(BRK - 3, 1);
      pulse_restart(); tick(1);
      chk("R4 break entered", tx_inhibit, 1);
      tick(d);
      chk("R4 still in break", tx_inhibit, 1);
      pulse_restart();
      count_tx(n);
      chk("R4 restarted break", n, tail_after_restart());
    end

    for (int k = 0; k < 16; k++) begin
      logic good;
      if (k == 0)      v = '0;
      else if (k == 1) v = '1;
      else if (k == 2) v = LN'(2);
      else             v = LN'($urandom_range((1 << LN) - 1, 0));
      good = pd_good(v);
      fresh_seek();
      fault_rd_clr = 1'b1; tick(1); fault_rd_clr = 1'b0;
      chk("R11 cleared", pd_fault, 0);
      pd_links = v; pd_eval = 1'b1; tick(1); pd_eval = 1'b0;
      chk("R10 pd complete", an_complete, int'(good));
      chk("R10 pd fault", pd_fault, int'(!good));
      tick(3);
      chk("R11 sticky", pd_fault, int'(!good));
    end

    fresh_seek();
    pd_links = '0; pd_eval = 1'b1; fault_rd_clr = 1'b1; tick(1);
    pd_eval = 1'b0;
    chk("R11 set beats clear", pd_fault, 1);
    tick(1); fault_rd_clr = 1'b0;
    chk("R11 clear", pd_fault, 0);

    mgmt_enable = 1'b0; tick(1);
    chk("R7 enable low", {29'd0, tx_inhibit, flp_enable, an_complete}, 0);
    pd_links = '0; pd_eval = 1'b1; tick(1); pd_eval = 1'b0;
    chk("R13 fault untouched", pd_fault, 0);
    pd_links = LN'(1); pd_eval = 1'b1; tick(1); pd_eval = 1'b0;
    chk("R13 complete untouched", an_complete, 0);
    mgmt_enable = 1'b1; tick(1);
    chk("R6 rise breaks", tx_inhibit, 1);

    rst_n = 1'b0; boot_forced = 1'b0; tick(2);
    rst_n = 1'b1;
    chk("R1 auto flp", flp_enable, 1);
    chk("R1 auto tx", tx_inhibit, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

endmodule